// File: doc/BRIEF.md
# PCM Highway Time-Slot Transmitter

This block places voice samples from several channels onto two serial transmit highways of a time-division PCM bus. Each frame starts at a frame-sync pulse. Each channel has three settings: a transmit slot number, a highway choice, and a sample format. The format is either 8-bit compressed, which fills one slot, or 16-bit linear, which fills a pair of adjacent slots. Three global settings apply to every channel: the launch edge of the bit clock, single-rate or half-rate bit timing, and a delay of 0 to 7 bit-clock periods between frame sync and the first data bit.

The block runs on a fast system clock and samples the bit clock and frame sync as ordinary synchronous inputs. Each channel offers a parallel sample together with a valid strobe. The block keeps the most recent valid sample and copies it into a per-channel snapshot at the start of a frame, so the whole frame is sent from one consistent set of samples. Each highway has a data line and a drive enable. The enable is high only during bits that belong to a slot assigned to that highway. The number of slots in a frame is set by the bit-clock rate and the spacing of the frame-sync pulses, at 64 kHz of bit clock per slot. For example, a 512 kHz bit clock gives 8 slots.

Top module: `pcm_slot_tx`

## Requirements
- R1: A channel whose highway field is 0 is sent on `dx[0]` / `dx_oe[0]`. A channel whose field is 1 is sent on `dx[1]` / `dx_oe[1]`.
- R2: A frame starts at a launch edge where `fsync` is 1 and was 0 at the previous launch edge. With offset 0, bit 7 (the MSB) of slot 0 is driven from that edge. Bits follow MSB first, and slot k starts at bit number 8k.
- R3: With `cfg_dbl`=0, each bit lasts one bit-clock period. With `cfg_dbl`=1, each bit is held for two consecutive launch edges.
- R4: With `cfg_fall`=0, outputs change only on rising edges of `bclk`. With `cfg_fall`=1, they change only on falling edges.
- R5: `cfg_ofs` (0 to 7) delays the first data bit by that many bit-clock periods after the frame-start edge. During the delay, both enables stay low.
- R6: A compressed channel (`ch_lin` bit 0) sends bits 7..0 of its sample in the slot equal to its 7-bit slot field.
- R7: A linear channel (`ch_lin` bit 1) with slot field n sends a 16-bit word in slots 2n and 2n+1. The word is sample bits [13:0], with bits 15 and 14 replaced by copies of bit 13. It is sent MSB first.
- R8: A highway's enable is high only during bits of a slot that is assigned to it. While the enable is low, its data line is 0.
- R9: When several channels claim the same bit on one highway, the channel with the lowest index drives it.
- R10: Each channel's latest valid sample is captured into the frame snapshot at frame start. A sample that arrives with its strobe during a frame does not change that frame and appears in the next frame.
- R11: A change on `smp_data` while the channel's `smp_vld` bit is 0 has no effect on transmitted data.
- R12: After reset, `dx` and `dx_oe` are 0, and no slot is driven until the first frame start, even while the bit clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock, sampled on clk |
| fsync | input | 1 | Frame sync, sampled at launch edges |
| cfg_dbl | input | 1 | 1: one bit per two bit-clock periods |
| cfg_fall | input | 1 | 1: launch on falling bclk edge |
| cfg_ofs | input | 3 | Bit-clock offset of slot 0 from frame sync |
| ch_slot | input | 28 | Per-channel 7-bit slot field, channel 0 in the low bits |
| ch_hwy | input | 4 | Per-channel highway select |
| ch_lin | input | 4 | Per-channel format: 1 linear, 0 compressed |
| smp_data | input | 64 | Per-channel 16-bit sample, channel 0 in the low bits |
| smp_vld | input | 4 | Per-channel sample strobe |
| dx | output | 2 | Serial data of highways 0 and 1 |
| dx_oe | output | 2 | Drive enables of highways 0 and 1 |

## Verification
Two events can fall in the same launch edge: a frame start that loads the snapshot, and the first transmitted bit. The snapshot taken in that edge must already supply slot 0's MSB. Samples with their strobe are also injected in the middle of a frame, in the same cycle as data edges. The scoreboard expects the old values for the rest of that frame and the new values in the next frame. Channels are also set to collide on one slot, so that priority and highway separation are judged on the same bit.

// File: rtl/pcm_slot_tx_pkg.sv
package pcm_slot_tx_pkg;
   // per-channel result toward the highway drivers
   typedef struct packed {
      logic hit;   // channel owns the current bit
      logic val;   // value of that bit
   } chan_bit_t;

   function automatic int pos_width(input int slot_w, input int ofs_w);
      // slot groups reach 2^(slot_w+1) slots, 8 bits each, doubled, plus offset
      return slot_w + 4 + 1 + ((ofs_w > 3) ? ofs_w - 3 : 0) + 1;
   endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
   import pcm_slot_tx_pkg::*;
#(
   parameter int SLOT_W = 7,
   parameter int OFS_W  = 3,
   localparam int POS_W  = pos_width(SLOT_W, OFS_W),
   localparam int SLOTX_W = POS_W - 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bclk,
   input  logic               fsync,
   input  logic               cfg_dbl,
   input  logic               cfg_fall,
   input  logic [OFS_W-1:0]   cfg_ofs,
   output logic               launch_ev,
   output logic               fs_start,
   output logic               in_data,
   output logic [SLOTX_W-1:0] slot_idx,
   output logic [2:0]         bit_idx
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic             bclk_q;
   logic             fs_prev;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] cur_pos;
   logic [POS_W-1:0] rel;
   logic [POS_W-1:0] bitnum;
   logic [POS_W-1:0] ofs_ext;

   assign ofs_ext   = POS_W'(cfg_ofs);
   assign launch_ev = cfg_fall ? (bclk_q & ~bclk) : (~bclk_q & bclk);
   assign fs_start  = launch_ev & fsync & ~fs_prev;

   always_comb begin
      if (fs_start)
         cur_pos = '0;
      else if (pos_q == POS_MAX)
         cur_pos = POS_MAX;
      else
         cur_pos = pos_q + 1'b1;
      in_data  = (cur_pos >= ofs_ext);
      rel      = cur_pos - ofs_ext;
      bitnum   = cfg_dbl ? (rel >> 1) : rel;
      slot_idx = bitnum[POS_W-1:3];
      bit_idx  = bitnum[2:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q  <= 1'b0;
         fs_prev <= 1'b0;
         pos_q   <= POS_MAX;
      end else begin
         bclk_q <= bclk;
         if (launch_ev) begin
            fs_prev <= fsync;
            pos_q   <= cur_pos;
         end
      end
   end

   // launch events sit on the programmed bclk polarity
   assert_launch_edge_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      launch_ev |-> (bclk == !cfg_fall));

   // a frame start always places the first bit at the offset, never inside it
   assert_frame_origin_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (fs_start && cfg_ofs != '0) |-> !in_data);
endmodule

// File: rtl/pcm_chan_slot.sv
module pcm_chan_slot
   import pcm_slot_tx_pkg::*;
#(
   parameter int SLOT_W  = 7,
   parameter int SLOTX_W = 10,
   parameter int SAMP_W  = 16,
   parameter bit LIN_EN  = 1'b1
) (
   input  logic               in_data,
   input  logic [SLOTX_W-1:0] slot_idx,
   input  logic [2:0]         bit_idx,
   input  logic [SLOT_W-1:0]  cfg_slot,
   input  logic               cfg_lin,
   input  logic [SAMP_W-1:0]  sample,
   output chan_bit_t          result
);
   logic      comp_hit;
   logic      comp_val;
   chan_bit_t lin_res;

   assign comp_hit = in_data && (slot_idx == SLOTX_W'(cfg_slot));
   assign comp_val = sample[3'd7 - bit_idx];

   generate
      if (LIN_EN) begin : g_linear
         logic [15:0] word;
         logic [3:0]  idx;
         assign word = {sample[13], sample[13], sample[13:0]};
         assign idx  = {slot_idx[0], bit_idx};
         assign lin_res.hit = in_data &&
                              (slot_idx[SLOTX_W-1:1] == (SLOTX_W-1)'(cfg_slot));
         assign lin_res.val = word[4'd15 - idx];
      end else begin : g_comp_only
         assign lin_res = '0;
      end
   endgenerate

   always_comb begin
      if (cfg_lin && LIN_EN) begin
         result = lin_res;
      end else begin
         result.hit = comp_hit;
         result.val = comp_val;
      end
   end
endmodule

// File: rtl/pcm_hwy_drive.sv
module pcm_hwy_drive
   import pcm_slot_tx_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int HSEL_W = 1,
   parameter int OFS_W  = 3,
   parameter int HWY_ID = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     launch_ev,
   input  logic                     fs_start,
   input  logic [OFS_W-1:0]         cfg_ofs,
   input  chan_bit_t [NUM_CH-1:0]   chan_res,
   input  logic [NUM_CH*HSEL_W-1:0] ch_hwy,
   output logic                     dx,
   output logic                     dx_oe
);
   logic win;
   logic win_val;

   // scan from the top so the lowest channel index overwrites last
   always_comb begin
      win     = 1'b0;
      win_val = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (chan_res[i].hit && (ch_hwy[i*HSEL_W +: HSEL_W] == HSEL_W'(HWY_ID))) begin
            win     = 1'b1;
            win_val = chan_res[i].val;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dx    <= 1'b0;
         dx_oe <= 1'b0;
      end else if (launch_ev) begin
         dx_oe <= win;
         dx    <= win & win_val;
      end
   end

   assert_quiet_off_edge_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !launch_ev |=> ($stable(dx) && $stable(dx_oe)));

   assert_offset_idle_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (fs_start && cfg_ofs != '0) |=> !dx_oe);

   assert_released_low_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !dx_oe |-> !dx);
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
   import pcm_slot_tx_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int NUM_HWY = 2,
   parameter int SLOT_W  = 7,
   parameter int SAMP_W  = 16,
   parameter int OFS_W   = 3,
   parameter bit LIN_EN  = 1'b1,
   localparam int HSEL_W = (NUM_HWY > 1) ? $clog2(NUM_HWY) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bclk,
   input  logic                     fsync,
   input  logic                     cfg_dbl,
   input  logic                     cfg_fall,
   input  logic [OFS_W-1:0]         cfg_ofs,
   input  logic [NUM_CH*SLOT_W-1:0] ch_slot,
   input  logic [NUM_CH*HSEL_W-1:0] ch_hwy,
   input  logic [NUM_CH-1:0]        ch_lin,
   input  logic [NUM_CH*SAMP_W-1:0] smp_data,
   input  logic [NUM_CH-1:0]        smp_vld,
   output logic [NUM_HWY-1:0]       dx,
   output logic [NUM_HWY-1:0]       dx_oe
);
   localparam int POS_W   = pos_width(SLOT_W, OFS_W);
   localparam int SLOTX_W = POS_W - 3;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("pcm_slot_tx: NUM_CH must be at least 1");
      end
      if (NUM_HWY < 2) begin : g_bad_hwy
         $error("pcm_slot_tx: NUM_HWY must be at least 2");
      end
      if (SAMP_W != 16) begin : g_bad_samp
         $error("pcm_slot_tx: SAMP_W must be 16");
      end
      if (OFS_W < 1 || OFS_W > 3) begin : g_bad_ofs
         $error("pcm_slot_tx: OFS_W must be 1 to 3");
      end
      if (SLOT_W < 1) begin : g_bad_slot
         $error("pcm_slot_tx: SLOT_W must be at least 1");
      end
   endgenerate

   logic               launch_ev;
   logic               fs_start;
   logic               in_data;
   logic [SLOTX_W-1:0] slot_idx;
   logic [2:0]         bit_idx;

   logic [NUM_CH*SAMP_W-1:0] pend_q;
   logic [NUM_CH*SAMP_W-1:0] snap_q;
   logic [NUM_CH*SAMP_W-1:0] snap_eff;
   chan_bit_t [NUM_CH-1:0]   chan_res;

   pcm_frame_timer #(
      .SLOT_W (SLOT_W),
      .OFS_W  (OFS_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk      (bclk),
      .fsync     (fsync),
      .cfg_dbl   (cfg_dbl),
      .cfg_fall  (cfg_fall),
      .cfg_ofs   (cfg_ofs),
      .launch_ev (launch_ev),
      .fs_start  (fs_start),
      .in_data   (in_data),
      .slot_idx  (slot_idx),
      .bit_idx   (bit_idx)
   );

   // the frame-start edge already transmits from the fresh snapshot
   assign snap_eff = fs_start ? pend_q : snap_q;

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_chan
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q[c*SAMP_W +: SAMP_W] <= '0;
               snap_q[c*SAMP_W +: SAMP_W] <= '0;
            end else begin
               if (smp_vld[c])
                  pend_q[c*SAMP_W +: SAMP_W] <= smp_data[c*SAMP_W +: SAMP_W];
               if (fs_start)
                  snap_q[c*SAMP_W +: SAMP_W] <= pend_q[c*SAMP_W +: SAMP_W];
            end
         end

         pcm_chan_slot #(
            .SLOT_W  (SLOT_W),
            .SLOTX_W (SLOTX_W),
            .SAMP_W  (SAMP_W),
            .LIN_EN  (LIN_EN)
         ) u_slot (
            .in_data  (in_data),
            .slot_idx (slot_idx),
            .bit_idx  (bit_idx),
            .cfg_slot (ch_slot[c*SLOT_W +: SLOT_W]),
            .cfg_lin  (ch_lin[c]),
            .sample   (snap_eff[c*SAMP_W +: SAMP_W]),
            .result   (chan_res[c])
         );
      end

      for (c = 0; c < NUM_HWY; c++) begin : g_hwy
         pcm_hwy_drive #(
            .NUM_CH (NUM_CH),
            .HSEL_W (HSEL_W),
            .OFS_W  (OFS_W),
            .HWY_ID (c)
         ) u_drive (
            .clk       (clk),
            .rst_n     (rst_n),
            .launch_ev (launch_ev),
            .fs_start  (fs_start),
            .cfg_ofs   (cfg_ofs),
            .chan_res  (chan_res),
            .ch_hwy    (ch_hwy),
            .dx        (dx[c]),
            .dx_oe     (dx_oe[c])
         );
      end
   endgenerate

   // a strobe away from frame start leaves the running frame's snapshot alone
   assert_snap_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (|smp_vld && !fs_start) |=> $stable(snap_q));
endmodule

// File: tb/sim_pcm_slot_tx.sv
module sim_pcm_slot_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        fsync = 1'b0;
   logic        cfg_dbl = 1'b0;
   logic        cfg_fall = 1'b0;
   logic [2:0]  cfg_ofs = '0;
   logic [27:0] ch_slot = '0;
   logic [3:0]  ch_hwy = '0;
   logic [3:0]  ch_lin = '0;
   logic [63:0] smp_data = '0;
   logic [3:0]  smp_vld = '0;
   logic [1:0]  dx;
   logic [1:0]  dx_oe;

   always #5 clk = ~clk;

   pcm_slot_tx u0 (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
      .cfg_dbl(cfg_dbl), .cfg_fall(cfg_fall), .cfg_ofs(cfg_ofs),
      .ch_slot(ch_slot), .ch_hwy(ch_hwy), .ch_lin(ch_lin),
      .smp_data(smp_data), .smp_vld(smp_vld), .dx(dx), .dx_oe(dx_oe)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int          slot_m [4];
   int          hwy_m  [4];
   bit          lin_m  [4];
   logic [15:0] pend_m [4];
   logic [15:0] snap_m [4];

   logic [3:0] exp_q [$];
   string      tag_q [$];
   event       launched;

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {oe,dx} actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // reference: {oe1,oe0,dx1,dx0} for launch edge e of a frame
   function automatic logic [3:0] expect_at(input int e);
      logic [1:0]  oe = '0;
      logic [1:0]  d  = '0;
      if (e >= int'(cfg_ofs)) begin
         int b  = (e - int'(cfg_ofs)) >> cfg_dbl;
         int sl = b / 8;
         int bt = b % 8;
         for (int h = 0; h < 2; h++) begin
            for (int c = 0; c < 4; c++) begin
               if (hwy_m[c] == h && !oe[h]) begin
                  if (lin_m[c]) begin
                     logic [15:0] w = {snap_m[c][13], snap_m[c][13], snap_m[c][13:0]};
                     if (sl / 2 == slot_m[c]) begin
                        oe[h] = 1'b1;
                        d[h]  = w[15 - ((sl % 2) * 8 + bt)];
                     end
                  end else if (sl == slot_m[c]) begin
                     oe[h] = 1'b1;
                     d[h]  = snap_m[c][7 - bt];
                  end
               end
            end
         end
      end
      return {oe, d};
   endfunction

   task automatic apply_cfg(input bit dbl, input bit fall, input int ofs);
      @(negedge clk);
      cfg_dbl  = dbl;
      cfg_fall = fall;
      cfg_ofs  = 3'(ofs);
      for (int c = 0; c < 4; c++) begin
         ch_slot[c*7 +: 7] = 7'(slot_m[c]);
         ch_hwy[c]         = hwy_m[c][0];
         ch_lin[c]         = lin_m[c];
      end
   endtask

   task automatic load_sample(input int c, input logic [15:0] v);
      @(negedge clk);
      smp_data[c*16 +: 16] = v;
      smp_vld[c] = 1'b1;
      @(negedge clk);
      smp_vld[c] = 1'b0;
      pend_m[c] = v;
   endtask

   // one bit-clock period per edge; expectations pushed before driving
   task automatic run_edges(input string tag, input int nev, input bit with_fs,
                            input int upd_at, input logic [15:0] upd_val);
      logic lvl = !cfg_fall;
      if (with_fs)
         for (int c = 0; c < 4; c++) snap_m[c] = pend_m[c];
      for (int e = 0; e < nev; e++) begin
         exp_q.push_back(with_fs ? expect_at(e) : 4'b0000);
         tag_q.push_back(tag);
         @(negedge clk);
         bclk = ~lvl;
         repeat (4) @(negedge clk);
         bclk  = lvl;
         fsync = with_fs && (e == 0);
         -> launched;
         repeat (3) @(negedge clk);
         if (e == upd_at) load_sample(0, upd_val);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic frame(input string tag, input int upd_at, input logic [15:0] upd_val);
      run_edges(tag, int'(cfg_ofs) + (64 << cfg_dbl), 1'b1, upd_at, upd_val);
   endtask

   // monitor: pops one expectation per launch edge
   initial begin
      forever begin
         @(launched);
         @(posedge clk);
         @(negedge clk);
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: unexpected edge, actual %b expected none", {dx_oe, dx});
         end else begin
            check(tag_q.pop_front(), {dx_oe, dx}, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) begin slot_m[c] = 0; hwy_m[c] = 0; lin_m[c] = 0; pend_m[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 reset", {dx_oe, dx}, 4'b0000);

      // R12: bit clock runs with slot 0 assigned but no frame sync
      apply_cfg(0, 0, 0);
      run_edges("R12 no frame", 20, 1'b0, -1, '0);

      // R1 R2 R6: compressed, single rate, rising, no offset
      slot_m = '{0, 3, 5, 7}; hwy_m = '{0, 1, 0, 1}; lin_m = '{0, 0, 0, 0};
      load_sample(0, 16'h00A5); load_sample(1, 16'h003C);
      load_sample(2, 16'h0081); load_sample(3, 16'h00F0);
      apply_cfg(0, 0, 0);
      frame("R1 R2 R6 compressed", -1, '0);

      // R3 R4 R5: half rate, falling launch, offset 3
      apply_cfg(1, 1, 3);
      frame("R3 R4 R5 dbl/fall/ofs3", -1, '0);

      // R7: linear groups mixed with compressed, sign copies forced
      slot_m = '{1, 0, 6, 3}; hwy_m = '{0, 1, 1, 0}; lin_m = '{1, 1, 0, 1};
      load_sample(0, 16'h2ABC); load_sample(1, 16'hD123);
      load_sample(2, 16'h005A); load_sample(3, 16'h1FFF);
      apply_cfg(0, 0, 0);
      frame("R7 linear", -1, '0);

      // R9 R8: collisions on slot 4, both highways
      slot_m = '{4, 4, 4, 4}; hwy_m = '{1, 0, 0, 1}; lin_m = '{0, 0, 0, 0};
      load_sample(0, 16'h00C3); load_sample(1, 16'h0055);
      load_sample(2, 16'h00AA); load_sample(3, 16'h00FF);
      apply_cfg(0, 1, 2);
      frame("R9 R8 priority", -1, '0);

      // R10: strobed update mid-frame must wait for the next frame
      slot_m = '{6, 1, 2, 3}; hwy_m = '{0, 1, 1, 0}; lin_m = '{0, 0, 0, 0};
      apply_cfg(0, 0, 0);
      frame("R10 snapshot hold", 20, 16'h0066);
      frame("R10 snapshot next", -1, '0);

      // R11: data without strobe is ignored
      @(negedge clk);
      smp_data[0 +: 16] = 16'h0099;
      smp_data[16 +: 16] = 16'h0011;
      frame("R11 no strobe", -1, '0);

      // R5 R3: maximum offset, half rate, rising, linear group 2
      slot_m = '{2, 7, 0, 3}; hwy_m = '{1, 0, 0, 1}; lin_m = '{1, 0, 1, 0};
      load_sample(0, 16'hE001);
      apply_cfg(1, 0, 7);
      frame("R5 R3 ofs7 linear", -1, '0);

      repeat (10) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule